// File: doc/BRIEF.md
# Conditional Branch Next-PC Unit

This block sits at the decode/fetch boundary of a 32-bit in-order core. For each presented instruction it checks whether the word is the immediate-form "branch if less than zero" instruction. If so, it tests the sign of the source register value supplied by the register-read stage and produces the next program counter, a taken flag and the number of cycles the branch costs the pipeline. Any other instruction simply advances the PC by four.

An immediate-prefix instruction can precede the branch to supply the upper 16 bits of a full 32-bit offset. Without a prefix, the 16-bit immediate is sign-extended. A branch may request a delay slot through its D bit. The instruction after such a branch is then flagged as a delay-slot instruction.

Prefixes, flow-control instructions and instructions that would raise a recoverable fault are not allowed in a delay slot. If one appears there, the block raises an error pulse and refuses to redirect. Interrupt and break requests are held back while a delayed branch and its slot instruction are still in progress, and are granted once the slot instruction has completed.

Top module: `bnpc_unit`

## Requirements
- R1: A word is a conditional branch only when bits [31:26] are 101111 and bits [24:21] are 0010. Bit 25 is the D bit, bits [20:16] name the source register and bits [15:0] are the immediate. Any other word, including opcode 101111 with a different [24:21], produces `br_taken`=0 and `next_pc`=`cur_pc`+4.
- R2: A conditional branch is taken exactly when bit 31 of `ra_value` is 1. `next_pc` is then `cur_pc` plus the offset, wrapping modulo 2^32. `cur_pc` must have its low two bits at zero whenever `instr_valid` is high.
- R3: A valid instruction that is not a taken branch gives `next_pc`=`cur_pc`+4 (modulo 2^32) and `br_taken`=0. When `instr_valid` is 0, `next_pc` is `cur_pc`+4, `br_taken` is 0 and `stall_cycles` is 0.
- R4: `stall_cycles` is 1 for a valid instruction that is not a taken branch, 2 for a taken branch with D=1 and 3 for a taken branch with D=0.
- R5: With no active prefix, the offset is the 16-bit immediate sign-extended. An immediate-prefix instruction has bits [31:26]=101100 and carries its value in bits [15:0]. When a prefix is active, the offset is {prefix value, immediate}.
- R6: A prefix is active only for the very next valid instruction. After that instruction it is cleared, whether or not that instruction was a branch. Cycles with `instr_valid`=0 do not consume it.
- R7: After a non-faulting conditional branch with D=1, whether taken or not, the next valid instruction is presented with `in_slot`=1. `in_slot` stays 1 through idle cycles until that instruction arrives.
- R8: A valid delay-slot instruction is forbidden if it is a prefix, has opcode 100110, 101110 or 101111, or arrives with `fault_hint`=1. A forbidden slot instruction gives `slot_err`=1 for that cycle, `br_taken`=0, `next_pc`=`cur_pc`+4 and `stall_cycles`=1. It neither arms a prefix nor opens a new delay slot.
- R9: A pulse on `irq_req` or `brk_req` is granted in the same cycle on `irq_grant`/`brk_grant` unless a hold is active. A hold is active while `in_slot` is 1 or while a non-faulting D=1 branch is being presented. A held request stays pending and is granted in the first cycle with no hold.
- R10: A synchronous active-high `rst` clears the prefix, the delay-slot flag and both pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| cur_pc | input | 32 | Address of the presented instruction |
| ra_value | input | 32 | Value of the source register |
| fault_hint | input | 1 | Presented instruction would raise a recoverable fault |
| irq_req | input | 1 | Interrupt request pulse |
| brk_req | input | 1 | External break request pulse |
| next_pc | output | 32 | Computed next program counter |
| br_taken | output | 1 | Branch redirect taken |
| in_slot | output | 1 | Presented instruction occupies a delay slot |
| stall_cycles | output | 2 | Cycle cost of the presented instruction |
| slot_err | output | 1 | Forbidden instruction in a delay slot |
| irq_grant | output | 1 | Interrupt delivered this cycle |
| brk_grant | output | 1 | Break delivered this cycle |

## Verification
Two functions can meet in one cycle: event deferral and delay-slot handling. A request can arrive while a D=1 branch is presented, or during its slot instruction, or at the moment a forbidden slot instruction raises an error. The bench pulses `irq_req` and `brk_req` in exactly those cycles. It expects no grant while the hold lasts and a grant in the first clean cycle, and a reset in the middle of a slot must drop the pending request. Prefix merging is also tested against a prefix placed inside a delay slot, which must be rejected and must not widen the next branch.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    localparam logic [5:0] OP_BCOND  = 6'b101111;
    localparam logic [5:0] OP_PREFIX = 6'b101100;
    localparam logic [5:0] OP_BRREG  = 6'b100110;
    localparam logic [5:0] OP_BRIMM  = 6'b101110;
    localparam logic [3:0] COND_LTZ  = 4'b0010;

    typedef enum logic [1:0] {
        K_OTHER  = 2'd0,
        K_PREFIX = 2'd1,
        K_BCOND  = 2'd2,
        K_FLOW   = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e       kind;
        logic        dly;
        logic [15:0] imm;
    } dec_t;

    function automatic logic [1:0] branch_cost(input logic valid, input logic tk, input logic d);
        if (!valid)  return 2'd0;
        else if (!tk) return 2'd1;
        else if (d)  return 2'd2;
        else         return 2'd3;
    endfunction

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
    import bnpc_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0] op;
    logic [3:0] cond;
    logic       unused_reg_field;

    assign op   = instr[31:26];
    assign cond = instr[24:21];
    assign unused_reg_field = ^instr[20:16];

    always_comb begin
        dec.dly = instr[25];
        dec.imm = instr[15:0];
        if (op == OP_PREFIX)
            dec.kind = K_PREFIX;
        else if (op == OP_BCOND && cond == COND_LTZ)
            dec.kind = K_BCOND;
        else if (op == OP_BCOND || op == OP_BRREG || op == OP_BRIMM)
            dec.kind = K_FLOW;
        else
            dec.kind = K_OTHER;
    end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            arm,
    input  logic            br_go,
    input  logic            ra_neg,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] next_pc,
    output logic            taken
);
    localparam int HIW = XLEN - IMMW;

    logic            pfx_q;
    logic [HIW-1:0]  hi_q;
    logic [XLEN-1:0] offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            pfx_q <= 1'b0;
            hi_q  <= '0;
        end else if (advance) begin
            pfx_q <= arm;
            if (arm)
                hi_q <= imm[HIW-1:0];
        end
    end

    always_comb begin
        if (pfx_q)
            offset = {hi_q, imm};
        else
            offset = {{HIW{imm[IMMW-1]}}, imm};
        taken   = br_go & ra_neg;
        next_pc = taken ? (pc + offset) : (pc + XLEN'(4));
    end

    // R6
    prefix_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !arm) |=> !pfx_q);

    // R6
    prefix_idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !$past(rst)) |=> $stable(pfx_q));
endmodule

// File: rtl/bnpc_defer.sv
module bnpc_defer #(
    parameter int NEVT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic [NEVT-1:0] req,
    output logic [NEVT-1:0] grant
);
    logic [NEVT-1:0] pend_q;

    for (genvar g = 0; g < NEVT; g++) begin : g_chan
        logic want;
        assign want     = req[g] | pend_q[g];
        assign grant[g] = want & ~hold;

        always_ff @(posedge clk) begin
            if (rst) pend_q[g] <= 1'b0;
            else     pend_q[g] <= want & hold;
        end

        // R9
        grant_not_held_chk: assert property (@(posedge clk) disable iff (rst)
            hold |-> !grant[g]);

        // R9
        pend_released_chk: assert property (@(posedge clk) disable iff (rst)
            (req[g] && hold) |=> (grant[g] || hold));
    end
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
    import bnpc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] ra_value,
    input  logic            fault_hint,
    input  logic            irq_req,
    input  logic            brk_req,
    output logic [XLEN-1:0] next_pc,
    output logic            br_taken,
    output logic            in_slot,
    output logic [1:0]      stall_cycles,
    output logic            slot_err,
    output logic            irq_grant,
    output logic            brk_grant
);
    dec_t       dec;
    logic       slot_q;
    logic       br_go;
    logic       arm;
    logic       hold;
    logic [1:0] grants;
    logic       unused_ra_low;

    assign unused_ra_low = ^ra_value[XLEN-2:0];

    bnpc_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    always_comb begin
        slot_err = instr_valid & slot_q & ((dec.kind != K_OTHER) | fault_hint);
        br_go    = instr_valid & (dec.kind == K_BCOND) & ~slot_err;
        arm      = instr_valid & (dec.kind == K_PREFIX) & ~slot_err;
        hold     = slot_q | (br_go & dec.dly);
    end

    bnpc_target #(.XLEN(XLEN), .IMMW(IMMW)) u_tgt (
        .clk     (clk),
        .rst     (rst),
        .advance (instr_valid),
        .arm     (arm),
        .br_go   (br_go),
        .ra_neg  (ra_value[XLEN-1]),
        .imm     (dec.imm[IMMW-1:0]),
        .pc      (cur_pc),
        .next_pc (next_pc),
        .taken   (br_taken)
    );

    always_ff @(posedge clk) begin
        if (rst)              slot_q <= 1'b0;
        else if (instr_valid) slot_q <= br_go & dec.dly;
    end

    assign in_slot      = slot_q;
    assign stall_cycles = branch_cost(instr_valid, br_taken, dec.dly);

    bnpc_defer #(.NEVT(2)) u_defer (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .req   ({brk_req, irq_req}),
        .grant (grants)
    );
    assign irq_grant = grants[0];
    assign brk_grant = grants[1];

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> (cur_pc[1:0] == 2'b00));

    // R8
    no_slot_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> (!br_taken && stall_cycles == 2'd1 && in_slot));

    // R4
    taken_cost_chk: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (stall_cycles == 2'd2 || stall_cycles == 2'd3));

    // R7
    slot_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (br_go && dec.dly) |=> in_slot);

    // R9
    slot_irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        in_slot |-> (!irq_grant && !brk_grant));

    // R8
    err_clears_slot_chk: assert property (@(posedge clk) disable iff (rst)
        slot_err |=> !in_slot);
endmodule

// File: tb/bnpc_unit_tb_top.sv
module bnpc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] cur_pc = 32'h0;
    logic [31:0] ra_value = 32'h0;
    logic        fault_hint = 1'b0;
    logic        irq_req = 1'b0;
    logic        brk_req = 1'b0;
    logic [31:0] next_pc;
    logic        br_taken, in_slot, slot_err, irq_grant, brk_grant;
    logic [1:0]  stall_cycles;

    always #(CLK_PERIOD/2) clk = ~clk;

    bnpc_unit dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .cur_pc(cur_pc), .ra_value(ra_value), .fault_hint(fault_hint),
        .irq_req(irq_req), .brk_req(brk_req), .next_pc(next_pc),
        .br_taken(br_taken), .in_slot(in_slot), .stall_cycles(stall_cycles),
        .slot_err(slot_err), .irq_grant(irq_grant), .brk_grant(brk_grant)
    );

    typedef struct {
        logic [31:0] npc;
        logic        tk;
        logic        slot;
        logic [1:0]  stall;
        logic        err;
        logic        ig;
        logic        bg;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    bit          m_pfx, m_slot, m_pi, m_pb;
    logic [15:0] m_hi;

    function automatic logic [31:0] bc(input logic d, input logic [4:0] ra, input logic [15:0] imm);
        return {6'b101111, d, 4'b0010, ra, imm};
    endfunction
    function automatic logic [31:0] pfx(input logic [15:0] hi);
        return {6'b101100, 10'b0, hi};
    endfunction
    localparam logic [31:0] NOP   = 32'h8000_0000;
    localparam logic [31:0] BRIMM = {6'b101110, 26'h0};

    task automatic model_reset();
        m_pfx = 0; m_slot = 0; m_pi = 0; m_pb = 0; m_hi = 16'h0;
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] pc,
                        input logic [31:0] ra, input logic f, input logic ir,
                        input logic br, input string tag);
        exp_t e;
        logic [5:0]  op;
        logic        d, isp, isb, isf, go, hold, wi, wb;
        logic [31:0] off;
        @(negedge clk);
        instr_valid = v; instr = w; cur_pc = pc; ra_value = ra;
        fault_hint = f; irq_req = ir; brk_req = br;
        op  = w[31:26];
        d   = w[25];
        isp = (op == 6'b101100);
        isb = (op == 6'b101111) && (w[24:21] == 4'b0010);
        isf = (op == 6'b101111) || (op == 6'b100110) || (op == 6'b101110);
        e.err  = v && m_slot && (isp || isf || f);
        go     = v && isb && !e.err;
        e.tk   = go && ra[31];
        off    = m_pfx ? {m_hi, w[15:0]} : {{16{w[15]}}, w[15:0]};
        e.npc  = e.tk ? pc + off : pc + 32'd4;
        e.stall = !v ? 2'd0 : (!e.tk ? 2'd1 : (d ? 2'd2 : 2'd3));
        e.slot = m_slot;
        hold   = m_slot || (go && d);
        wi = ir || m_pi;
        wb = br || m_pb;
        e.ig = wi && !hold;
        e.bg = wb && !hold;
        e.tag = tag;
        exp_q.push_back(e);
        m_pi = wi && hold;
        m_pb = wb && hold;
        if (v) begin
            m_pfx = isp && !e.err;
            if (isp && !e.err) m_hi = w[15:0];
            m_slot = go && d;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; instr_valid = 1'b0; irq_req = 1'b0; brk_req = 1'b0; fault_hint = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (next_pc !== e.npc || br_taken !== e.tk || in_slot !== e.slot ||
                    stall_cycles !== e.stall || slot_err !== e.err ||
                    irq_grant !== e.ig || brk_grant !== e.bg) begin
                    errors++;
                    $display("FAIL %s: got npc=%h tk=%b slot=%b stall=%0d err=%b ig=%b bg=%b exp npc=%h tk=%b slot=%b stall=%0d err=%b ig=%b bg=%b",
                             e.tag, next_pc, br_taken, in_slot, stall_cycles, slot_err, irq_grant, brk_grant,
                             e.npc, e.tk, e.slot, e.stall, e.err, e.ig, e.bg);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        model_reset();
        do_reset();
        // R10 reset state
        step(1, NOP, 32'h100, 32'h0, 0, 0, 0, "R10 reset state");
        // R3 idle
        step(0, NOP, 32'h104, 32'h0, 0, 0, 0, "R3 idle");
        // R2 R3 not taken
        step(1, bc(0, 5'd3, 16'h0040), 32'h200, 32'h0000_0005, 0, 0, 0, "R3 not taken");
        // R1 wrong cond field
        step(1, {6'b101111, 1'b0, 4'b0011, 5'd1, 16'h0040}, 32'h204, 32'h8000_0000, 0, 0, 0, "R1 cond mismatch");
        // R2 R4 taken D=0
        step(1, bc(0, 5'd3, 16'h0040), 32'h300, 32'hFFFF_FFFF, 0, 0, 0, "R4 taken nodelay");
        // R4 R7 taken D=1 negative imm
        step(1, bc(1, 5'd3, 16'hFFF0), 32'h400, 32'h8000_0000, 0, 0, 0, "R4 taken delay");
        // R7 idle keeps slot
        step(0, NOP, 32'h404, 32'h0, 0, 0, 0, "R7 idle in slot");
        step(1, NOP, 32'h404, 32'h0, 0, 0, 0, "R7 slot instr");
        // R7 not-taken D=1 still opens slot
        step(1, bc(1, 5'd2, 16'h0010), 32'h500, 32'h1, 0, 0, 0, "R7 nt delay");
        step(1, NOP, 32'h504, 32'h0, 0, 0, 0, "R7 nt slot");
        // R5 prefix merge
        step(1, pfx(16'h0001), 32'h600, 32'h0, 0, 0, 0, "R5 prefix");
        step(1, bc(0, 5'd4, 16'h8000), 32'h604, 32'h8000_0000, 0, 0, 0, "R5 merged offset");
        // R6 prefix consumed by nop
        step(1, pfx(16'h0001), 32'h700, 32'h0, 0, 0, 0, "R6 prefix");
        step(0, NOP, 32'h704, 32'h0, 0, 0, 0, "R6 idle");
        step(1, NOP, 32'h704, 32'h0, 0, 0, 0, "R6 consume");
        step(1, bc(0, 5'd4, 16'h8000), 32'h708, 32'h8000_0000, 0, 0, 0, "R6 sext after consume");
        // R8 branch in slot
        step(1, bc(1, 5'd1, 16'h0100), 32'h800, 32'h8000_0000, 0, 0, 0, "R8 delay br");
        step(1, bc(1, 5'd1, 16'h0200), 32'h900, 32'h8000_0000, 0, 0, 0, "R8 branch in slot");
        step(1, NOP, 32'h904, 32'h0, 0, 0, 0, "R8 no new slot");
        // R8 prefix in slot rejected
        step(1, bc(1, 5'd1, 16'h0100), 32'hA00, 32'h8000_0000, 0, 0, 0, "R8 delay br2");
        step(1, pfx(16'h0007), 32'hB00, 32'h0, 0, 0, 0, "R8 prefix in slot");
        step(1, bc(0, 5'd1, 16'h8000), 32'hB04, 32'h8000_0000, 0, 0, 0, "R8 no prefix armed");
        // R8 unconditional flow and fault in slot
        step(1, bc(1, 5'd1, 16'h0100), 32'hC00, 32'h8000_0000, 0, 0, 0, "R8 delay br3");
        step(1, BRIMM, 32'hD00, 32'h0, 0, 0, 0, "R8 flow in slot");
        step(1, bc(1, 5'd1, 16'h0100), 32'hC00, 32'h8000_0000, 0, 0, 0, "R8 delay br4");
        step(1, NOP, 32'hD00, 32'h0, 1, 1, 0, "R8 fault in slot");
        step(1, NOP, 32'hD04, 32'h0, 0, 0, 0, "R9 grant after err slot");
        // R9 immediate grant
        step(1, NOP, 32'hE00, 32'h0, 0, 1, 1, "R9 immediate grant");
        // R9 deferral across delayed branch
        step(1, bc(1, 5'd1, 16'h0020), 32'hF00, 32'h8000_0000, 0, 1, 0, "R9 irq at branch");
        step(1, NOP, 32'hF04, 32'h0, 0, 0, 1, "R9 brk in slot");
        step(1, NOP, 32'hF20, 32'h0, 0, 0, 0, "R9 release");
        // R9 chained delayed branch after slot keeps holding
        step(1, bc(1, 5'd1, 16'h0020), 32'h1000, 32'h8000_0000, 0, 0, 1, "R9 brk at br");
        step(1, NOP, 32'h1004, 32'h0, 0, 0, 0, "R9 slot a");
        step(1, bc(1, 5'd1, 16'h0020), 32'h1020, 32'h8000_0000, 0, 0, 0, "R9 second delay br");
        step(1, NOP, 32'h1024, 32'h0, 0, 0, 0, "R9 slot b");
        step(1, NOP, 32'h1040, 32'h0, 0, 0, 0, "R9 late release");
        // R2 wrap
        step(1, NOP, 32'hFFFF_FFFC, 32'h0, 0, 0, 0, "R3 wrap seq");
        step(1, bc(0, 5'd1, 16'h0010), 32'hFFFF_FFF8, 32'h8000_0000, 0, 0, 0, "R2 wrap taken");
        // R10 reset mid-slot drops pending
        step(1, bc(1, 5'd1, 16'h0020), 32'h2000, 32'h8000_0000, 0, 1, 1, "R10 pre reset");
        do_reset();
        step(1, NOP, 32'h3000, 32'h0, 0, 0, 0, "R10 cleared");
        step(1, bc(0, 5'd1, 16'h8000), 32'h3004, 32'h8000_0000, 0, 0, 0, "R10 prefix cleared");
        @(negedge clk);
        instr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule